// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

A synchronous behavioural stand-in for the command side of a 16-bit-wide NOR-style flash. It watches an active-low parallel bus (chip enable, write enable, output enable, address, data) sampled on a system clock. It recognises the multi-cycle protected command sequences that alter the array: word program, sector erase, block erase and whole-array erase. It also recognises entry to and exit from an identification query mode.

Once a program or erase sequence completes, the block enters a busy period whose length is set by a parameter in clock cycles. During that period, reads return status instead of array data. Bit 7 is a polarity flag and bit 6 toggles on each completed read. Every further write is ignored until the period ends, and then the array change is committed. The array is a small register model that resets to all ones. Erase sets whole regions to ones, and program can only clear bits.

Top module: `flash_cmd_model`

## Requirements
- R1: A bus write occurs only while ce_n and we_n are both low and oe_n is high. The address is taken from the first clock of that window and the data from its last clock. A window with oe_n low has no effect.
- R2: dq_oe is 1 only while ce_n and oe_n are both low. Whenever dq_oe is 0, dq_out is 0.
- R3: After reset every array word reads 16'hFFFF. An idle read returns the word at index addr[IDX_W-1:0].
- R4: Writing AAh to 5555h, 55h to 2AAAh, A0h to 5555h and then data D to address A leaves word A equal to its old value AND D. The change is committed no later than PROG_CYCLES+2 clocks after the fourth write.
- R5: The six-write sequence AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 30h@A sets to FFFFh every word in the SECTOR_WORDS-aligned region holding A. No other word changes.
- R6: The same prefix ending in 50h@A sets to FFFFh the BLOCK_WORDS-aligned region holding A. No other word changes.
- R7: The prefix ending in 10h@5555h sets every word to FFFFh. A final 10h at any other address cancels the sequence with no busy period.
- R8: While busy, a read returns 0 in every bit except 7 and 6. Bit 7 is the complement of bit 7 of the word being programmed, or 0 during any erase.
- R9: While busy, bit 6 inverts between successive reads. Once idle, repeated reads of a word return the same value.
- R10: Writes issued while busy change neither the operation in progress nor the array.
- R11: A write that does not match the expected step of a protected sequence returns the block to read mode. A following data write then programs nothing.
- R12: AAh@5555h, 55h@2AAAh, 98h@5555h enters query mode. Query mode returns 0051h, 0052h and 0059h at addresses 10h, 11h and 12h, log2 of the array size in bytes at 27h, and 0 elsewhere. It stays active until F0h is written to any address, after which array reads resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | DATA_W | Write data from the host |
| dq_out | output | DATA_W | Read data toward the host, 0 when not driven |
| dq_oe | output | 1 | High while the block drives the data bus |

## Verification
The assertions assume that every bus signal changes only between clock edges. They also assume that a write window and a read window never overlap, and that a write window lasts at least one clock. The stimulus drives ce_n, we_n, oe_n, addr and dq_in only on falling clock edges. It holds each window for two clocks with an idle gap of two clocks, and it never lowers we_n and oe_n together except in the deliberate inhibited-write case. Random program and erase operations fill the array and are checked against a word-accurate model. Directed cases cover aborts, lockout during busy, query mode and the sampling points of address and data.

// File: rtl/fcm_pkg.sv
package fcm_pkg;

   typedef enum logic [3:0] {
      ST_READ,
      ST_UNLK1,
      ST_UNLK2,
      ST_PGM_DATA,
      ST_ERS3,
      ST_ERS4,
      ST_ERS5,
      ST_QUERY,
      ST_BUSY
   } fcm_state_e;

   typedef enum logic [1:0] {
      OP_PROG,
      OP_SECT,
      OP_BLOCK,
      OP_CHIP
   } fcm_op_e;

   localparam logic [7:0] CMD_KEY1    = 8'hAA;
   localparam logic [7:0] CMD_KEY2    = 8'h55;
   localparam logic [7:0] CMD_PROG    = 8'hA0;
   localparam logic [7:0] CMD_ERS_SET = 8'h80;
   localparam logic [7:0] CMD_SECT    = 8'h30;
   localparam logic [7:0] CMD_BLOCK   = 8'h50;
   localparam logic [7:0] CMD_CHIP    = 8'h10;
   localparam logic [7:0] CMD_QUERY   = 8'h98;
   localparam logic [7:0] CMD_EXIT    = 8'hF0;

   localparam logic [15:0] ADR_KEY_A  = 16'h5555;
   localparam logic [15:0] ADR_KEY_B  = 16'h2AAA;

endpackage

// File: rtl/fcm_bus_sampler.sv
module fcm_bus_sampler
   import fcm_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] dq_in,
   output logic              wr_pulse,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              rd_done
);

   logic wr_act, wr_act_q;
   logic rd_act, rd_act_q;

   // Write window: both strobes low, output enable high (inhibit otherwise)
   assign wr_act = !ce_n && !we_n && oe_n;
   assign rd_act = !ce_n && !oe_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_act_q <= 1'b0;
         rd_act_q <= 1'b0;
         wr_pulse <= 1'b0;
         rd_done  <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else begin
         wr_act_q <= wr_act;
         rd_act_q <= rd_act;
         // Address on the opening of the window (later falling strobe)
         if (wr_act && !wr_act_q) wr_addr <= addr;
         // Data keeps following the bus until the window closes
         if (wr_act) wr_data <= dq_in;
         wr_pulse <= !wr_act && wr_act_q;
         rd_done  <= !rd_act && rd_act_q;
      end
   end

endmodule

// File: rtl/fcm_cmd_fsm.sv
module fcm_cmd_fsm
   import fcm_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int DATA_W       = 16,
   parameter int IDX_W        = 8,
   parameter int PROG_CYCLES  = 64,
   parameter int ERASE_CYCLES = 512,
   parameter int CHIP_CYCLES  = 1024,
   parameter bit QUERY_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_pulse,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              busy,
   output logic              query_mode,
   output fcm_op_e           op,
   output logic [IDX_W-1:0]  op_idx,
   output logic [DATA_W-1:0] op_data,
   output logic              commit
);

   localparam int MAX_BUSY = (PROG_CYCLES > ERASE_CYCLES)
                             ? ((PROG_CYCLES > CHIP_CYCLES) ? PROG_CYCLES : CHIP_CYCLES)
                             : ((ERASE_CYCLES > CHIP_CYCLES) ? ERASE_CYCLES : CHIP_CYCLES);
   localparam int CNT_W    = $clog2(MAX_BUSY + 1);

   fcm_state_e       state;
   logic [CNT_W-1:0] timer;
   logic [7:0]       cmd;
   logic             at_a, at_b;

   assign cmd        = wr_data[7:0];
   assign at_a       = (wr_addr == ADDR_W'(ADR_KEY_A));
   assign at_b       = (wr_addr == ADDR_W'(ADR_KEY_B));
   assign busy       = (state == ST_BUSY);
   assign query_mode = (state == ST_QUERY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_READ;
         timer   <= '0;
         op      <= OP_PROG;
         op_idx  <= '0;
         op_data <= '0;
         commit  <= 1'b0;
      end else begin
         commit <= 1'b0;
         if (state == ST_BUSY) begin
            // Writes are ignored here: only the timer advances
            if (timer == '0) begin
               commit <= 1'b1;
               state  <= ST_READ;
            end else begin
               timer <= timer - 1'b1;
            end
         end else if (wr_pulse) begin
            unique case (state)
               ST_READ:  state <= (at_a && cmd == CMD_KEY1) ? ST_UNLK1 : ST_READ;
               ST_UNLK1: state <= (at_b && cmd == CMD_KEY2) ? ST_UNLK2 : ST_READ;
               ST_UNLK2: begin
                  if (at_a && cmd == CMD_PROG)                   state <= ST_PGM_DATA;
                  else if (at_a && cmd == CMD_ERS_SET)           state <= ST_ERS3;
                  else if (QUERY_EN && at_a && cmd == CMD_QUERY) state <= ST_QUERY;
                  else                                           state <= ST_READ;
               end
               ST_PGM_DATA: begin
                  op      <= OP_PROG;
                  op_idx  <= wr_addr[IDX_W-1:0];
                  op_data <= wr_data;
                  timer   <= CNT_W'(PROG_CYCLES - 1);
                  state   <= ST_BUSY;
               end
               ST_ERS3: state <= (at_a && cmd == CMD_KEY1) ? ST_ERS4 : ST_READ;
               ST_ERS4: state <= (at_b && cmd == CMD_KEY2) ? ST_ERS5 : ST_READ;
               ST_ERS5: begin
                  op_idx  <= wr_addr[IDX_W-1:0];
                  op_data <= wr_data;
                  if (cmd == CMD_SECT) begin
                     op    <= OP_SECT;
                     timer <= CNT_W'(ERASE_CYCLES - 1);
                     state <= ST_BUSY;
                  end else if (cmd == CMD_BLOCK) begin
                     op    <= OP_BLOCK;
                     timer <= CNT_W'(ERASE_CYCLES - 1);
                     state <= ST_BUSY;
                  end else if (cmd == CMD_CHIP && at_a) begin
                     op    <= OP_CHIP;
                     timer <= CNT_W'(CHIP_CYCLES - 1);
                     state <= ST_BUSY;
                  end else begin
                     state <= ST_READ;
                  end
               end
               ST_QUERY: state <= (cmd == CMD_EXIT) ? ST_READ : ST_QUERY;
               default:  state <= ST_READ;
            endcase
         end
      end
   end

endmodule

// File: rtl/fcm_array.sv
module fcm_array
   import fcm_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int ARRAY_WORDS  = 256,
   parameter int SECTOR_WORDS = 16,
   parameter int BLOCK_WORDS  = 64,
   parameter int IDX_W        = $clog2(ARRAY_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  fcm_op_e           op,
   input  logic [IDX_W-1:0]  op_idx,
   input  logic [DATA_W-1:0] op_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);

   localparam logic [IDX_W-1:0] SECT_KEEP  = ~IDX_W'(SECTOR_WORDS - 1);
   localparam logic [IDX_W-1:0] BLOCK_KEEP = ~IDX_W'(BLOCK_WORDS - 1);

   logic [DATA_W-1:0] mem [ARRAY_WORDS];
   logic [IDX_W-1:0]  keep;

   // Index bits that must match the target for a word to be erased
   always_comb begin
      unique case (op)
         OP_SECT:  keep = SECT_KEEP;
         OP_BLOCK: keep = BLOCK_KEEP;
         default:  keep = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ARRAY_WORDS; i++) mem[i] <= '1;
      end else if (commit) begin
         if (op == OP_PROG) begin
            // Program can only pull bits from 1 to 0
            mem[op_idx] <= mem[op_idx] & op_data;
         end else begin
            for (int i = 0; i < ARRAY_WORDS; i++) begin
               if ((IDX_W'(i) & keep) == (op_idx & keep)) mem[i] <= '1;
            end
         end
      end
   end

   assign rd_data = mem[rd_idx];

endmodule

// File: rtl/fcm_toggle.sv
module fcm_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   input  logic rd_done,
   output logic tog
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tog <= 1'b0;
      else if (!busy)   tog <= 1'b0;
      else if (rd_done) tog <= ~tog;
   end

endmodule

// File: rtl/flash_cmd_model.sv
module flash_cmd_model
   import fcm_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int DATA_W       = 16,
   parameter int ARRAY_WORDS  = 256,
   parameter int SECTOR_WORDS = 16,
   parameter int BLOCK_WORDS  = 64,
   parameter int PROG_CYCLES  = 64,
   parameter int ERASE_CYCLES = 512,
   parameter int CHIP_CYCLES  = 1024,
   parameter bit QUERY_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe
);

   localparam int IDX_W    = $clog2(ARRAY_WORDS);
   localparam int MAX_BUSY = (PROG_CYCLES > ERASE_CYCLES)
                             ? ((PROG_CYCLES > CHIP_CYCLES) ? PROG_CYCLES : CHIP_CYCLES)
                             : ((ERASE_CYCLES > CHIP_CYCLES) ? ERASE_CYCLES : CHIP_CYCLES);

   // Elaboration-time parameter checks
   if (DATA_W < 8) begin : g_bad_data_w
      $error("DATA_W must hold an 8-bit command");
   end
   if (ADDR_W < 15 || ADDR_W < IDX_W) begin : g_bad_addr_w
      $error("ADDR_W too narrow for command addresses or array");
   end
   if ((ARRAY_WORDS & (ARRAY_WORDS - 1)) != 0 || ARRAY_WORDS < 2) begin : g_bad_depth
      $error("ARRAY_WORDS must be a power of two");
   end
   if ((SECTOR_WORDS & (SECTOR_WORDS - 1)) != 0 ||
       (BLOCK_WORDS & (BLOCK_WORDS - 1)) != 0 ||
       SECTOR_WORDS > BLOCK_WORDS || BLOCK_WORDS > ARRAY_WORDS) begin : g_bad_region
      $error("region sizes must be powers of two, sector <= block <= array");
   end
   if (PROG_CYCLES < 1 || ERASE_CYCLES < 1 || CHIP_CYCLES < 1) begin : g_bad_time
      $error("busy durations must be at least one cycle");
   end

   logic              wr_pulse, rd_done;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic              busy, query_mode, commit, tog;
   fcm_op_e           op;
   logic [IDX_W-1:0]  op_idx;
   logic [DATA_W-1:0] op_data;
   logic [DATA_W-1:0] arr_rd, query_rd;

   fcm_bus_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sampler (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .dq_in(dq_in), .wr_pulse(wr_pulse), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_done(rd_done)
   );

   fcm_cmd_fsm #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
      .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES),
      .CHIP_CYCLES(CHIP_CYCLES), .QUERY_EN(QUERY_EN)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .wr_addr(wr_addr),
      .wr_data(wr_data), .busy(busy), .query_mode(query_mode), .op(op),
      .op_idx(op_idx), .op_data(op_data), .commit(commit)
   );

   fcm_array #(
      .DATA_W(DATA_W), .ARRAY_WORDS(ARRAY_WORDS), .SECTOR_WORDS(SECTOR_WORDS),
      .BLOCK_WORDS(BLOCK_WORDS), .IDX_W(IDX_W)
   ) u_array (
      .clk(clk), .rst_n(rst_n), .commit(commit), .op(op), .op_idx(op_idx),
      .op_data(op_data), .rd_idx(addr[IDX_W-1:0]), .rd_data(arr_rd)
   );

   fcm_toggle u_toggle (
      .clk(clk), .rst_n(rst_n), .busy(busy), .rd_done(rd_done), .tog(tog)
   );

   // Query table: present only when the mode is enabled
   if (QUERY_EN) begin : g_query
      always_comb begin
         unique case (addr)
            ADDR_W'(8'h10): query_rd = DATA_W'(16'h0051);
            ADDR_W'(8'h11): query_rd = DATA_W'(16'h0052);
            ADDR_W'(8'h12): query_rd = DATA_W'(16'h0059);
            ADDR_W'(8'h27): query_rd = DATA_W'(IDX_W + 1);
            default:        query_rd = '0;
         endcase
      end
   end else begin : g_no_query
      assign query_rd = '0;
   end

   assign dq_oe = !ce_n && !oe_n;

   always_comb begin
      dq_out = '0;
      if (dq_oe) begin
         if (busy) begin
            dq_out[7] = (op == OP_PROG) ? ~op_data[7] : 1'b0;
            dq_out[6] = tog;
         end else if (query_mode) begin
            dq_out = query_rd;
         end else begin
            dq_out = arr_rd;
         end
      end
   end

endmodule

// File: rtl/fcm_checker.sv
module fcm_checker
   import fcm_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int IDX_W    = 8,
   parameter int MAX_BUSY = 1024
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              oe_n,
   input logic [DATA_W-1:0] dq_out,
   input logic              dq_oe,
   input logic              busy,
   input fcm_op_e           op,
   input logic [IDX_W-1:0]  op_idx,
   input logic [DATA_W-1:0] op_data,
   input logic              wr_pulse,
   input logic              commit
);

   logic [31:0] busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_run <= '0;
      else if (busy) busy_run <= busy_run + 1;
      else           busy_run <= '0;
   end

   p_bus_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n || oe_n) |-> (!dq_oe && dq_out == '0));

   p_poll_prog_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op == OP_PROG && dq_oe) |-> (dq_out[7] == ~op_data[7]));

   p_poll_erase_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op != OP_PROG && dq_oe) |-> !dq_out[7]);

   p_lockout_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_pulse) |=> ($stable(op) && $stable(op_idx) && $stable(op_data)));

   p_commit_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> $past(busy));

   p_busy_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run <= 32'(MAX_BUSY) + 32'd1);

endmodule

bind flash_cmd_model fcm_checker #(
   .DATA_W(DATA_W), .IDX_W(IDX_W), .MAX_BUSY(MAX_BUSY)
) u_fcm_checker (
   .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .dq_out(dq_out),
   .dq_oe(dq_oe), .busy(busy), .op(op), .op_idx(op_idx), .op_data(op_data),
   .wr_pulse(wr_pulse), .commit(commit)
);

// File: tb/flash_cmd_model_tb_top.sv
module flash_cmd_model_tb_top;

   localparam int AW    = 16;
   localparam int DW    = 16;
   localparam int WORDS = 256;
   localparam int SECT  = 16;
   localparam int BLK   = 64;
   localparam int PCYC  = 40;
   localparam int ECYC  = 120;
   localparam int CCYC  = 200;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] dq_in = '0;
   logic [DW-1:0] dq_out;
   logic          dq_oe;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [15:0] ref_mem [WORDS];

   always #5 clk = ~clk;

   flash_cmd_model #(
      .ADDR_W(AW), .DATA_W(DW), .ARRAY_WORDS(WORDS), .SECTOR_WORDS(SECT),
      .BLOCK_WORDS(BLK), .PROG_CYCLES(PCYC), .ERASE_CYCLES(ECYC),
      .CHIP_CYCLES(CCYC), .QUERY_EN(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bwr(input logic [15:0] a, input logic [15:0] d);
      @(negedge clk); addr = a; dq_in = d; ce_n = 1'b0; we_n = 1'b0;
      @(negedge clk);
      @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
   endtask

   // Address moves and data settles in the middle of the window
   task automatic bwr_shift(input logic [15:0] a0, input logic [15:0] a1,
                            input logic [15:0] d0, input logic [15:0] d1);
      @(negedge clk); addr = a0; dq_in = d0; ce_n = 1'b0; we_n = 1'b0;
      @(negedge clk); addr = a1; dq_in = d1;
      @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic brd(input logic [15:0] a, output logic [15:0] d, output logic en);
      @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
      #1; d = dq_out; en = dq_oe;
      @(negedge clk); oe_n = 1'b1; ce_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic keys();
      bwr(16'h5555, 16'h00AA);
      bwr(16'h2AAA, 16'h0055);
   endtask

   task automatic start_prog(input logic [15:0] a, input logic [15:0] d);
      keys();
      bwr(16'h5555, 16'h00A0);
      bwr(a, d);
   endtask

   task automatic start_erase(input logic [7:0] code, input logic [15:0] a);
      keys();
      bwr(16'h5555, 16'h0080);
      keys();
      bwr(a, {8'h00, code});
   endtask

   task automatic wait_idle();
      repeat (CCYC + 20) @(negedge clk);
   endtask

   function automatic void ref_erase(input int a, input int size);
      for (int i = 0; i < WORDS; i++)
         if ((i / size) == (a / size)) ref_mem[i] = 16'hFFFF;
   endfunction

   task automatic check_word(input string req, input int a);
      logic [15:0] d;
      logic        en;
      brd(16'(a), d, en);
      chk(req, d, ref_mem[a]);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] r0, r1, r2;
      logic        e0, e1;
      void'($urandom(32'd51966));
      for (int i = 0; i < WORDS; i++) ref_mem[i] = 16'hFFFF;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3: reset content
      check_word("R3 reset word 0", 0);
      check_word("R3 reset last word", WORDS - 1);

      // R2: bus released unless both ce_n and oe_n low
      @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; #1;
      chk("R2 oe high", {15'd0, dq_oe}, 16'd0);
      chk("R2 oe high data", dq_out, 16'd0);
      @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; #1;
      chk("R2 ce high", {15'd0, dq_oe}, 16'd0);
      @(negedge clk); oe_n = 1'b1;
      brd(16'h0003, r0, e0);
      chk("R2 driven", {15'd0, e0}, 16'd1);

      // R4, R8, R9: program with status polling
      start_prog(16'h0021, 16'h1234);
      brd(16'h0021, r1, e1);
      brd(16'h0021, r2, e1);
      chk("R8 prog status", r1 & 16'hFFBF, 16'h0080);
      chk("R9 dq6 flips", {15'd0, r2[6]}, {15'd0, ~r1[6]});
      wait_idle();
      ref_mem[16'h21] = 16'h1234;
      check_word("R4 program", 16'h21);
      brd(16'h0021, r1, e1);
      brd(16'h0021, r2, e1);
      chk("R9 stable when idle", r2, r1);

      // R4: program only clears bits
      start_prog(16'h0021, 16'h00FF);
      wait_idle();
      ref_mem[16'h21] = 16'h1234 & 16'h00FF;
      check_word("R4 and-program", 16'h21);

      // R1: address from window start, data from window end
      keys();
      bwr(16'h5555, 16'h00A0);
      bwr_shift(16'h0030, 16'h0031, 16'hFFFF, 16'h5A0F);
      wait_idle();
      ref_mem[16'h30] = 16'h5A0F;
      check_word("R1 address at start", 16'h30);
      check_word("R1 other address untouched", 16'h31);

      // R1: write with oe_n low is inhibited, sequence then fails
      @(negedge clk); addr = 16'h5555; dq_in = 16'h00AA; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
      @(negedge clk);
      @(negedge clk); we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
      repeat (2) @(negedge clk);
      bwr(16'h2AAA, 16'h0055);
      bwr(16'h5555, 16'h00A0);
      bwr(16'h0040, 16'h0000);
      wait_idle();
      check_word("R1 inhibited write", 16'h40);

      // R11: wrong third command, then a wrong second address
      keys();
      bwr(16'h5555, 16'h0077);
      bwr(16'h0041, 16'h0000);
      wait_idle();
      check_word("R11 bad command abort", 16'h41);
      bwr(16'h5555, 16'h00AA);
      bwr(16'h1111, 16'h0055);
      bwr(16'h5555, 16'h00A0);
      bwr(16'h0042, 16'h0000);
      wait_idle();
      check_word("R11 bad address abort", 16'h42);

      // R5, R8, R10: sector erase with polling and lockout
      start_prog(16'h0012, 16'h0F0F);
      wait_idle();
      ref_mem[16'h12] = 16'h0F0F;
      start_erase(8'h30, 16'h001A);
      brd(16'h001A, r1, e1);
      chk("R8 erase status", r1 & 16'hFFBF, 16'h0000);
      start_prog(16'h0080, 16'h0000);
      wait_idle();
      ref_erase(16'h1A, SECT);
      check_word("R5 sector erased", 16'h12);
      check_word("R5 neighbour sector kept", 16'h21);
      check_word("R10 lockout", 16'h80);

      // R12: query mode
      keys();
      bwr(16'h5555, 16'h0098);
      brd(16'h0010, r0, e0); chk("R12 q10", r0, 16'h0051);
      brd(16'h0011, r0, e0); chk("R12 q11", r0, 16'h0052);
      brd(16'h0012, r0, e0); chk("R12 q12", r0, 16'h0059);
      brd(16'h0027, r0, e0); chk("R12 size", r0, 16'h0009);
      brd(16'h0021, r0, e0); chk("R12 other", r0, 16'h0000);
      bwr(16'h0000, 16'h00F0);
      check_word("R12 after exit", 16'h21);

      // Random program / erase traffic against the bench model
      for (int it = 0; it < 24; it++) begin
         int          kind, a;
         logic [15:0] d;
         kind = int'($urandom % 8);
         a    = int'($urandom % WORDS);
         d    = 16'($urandom);
         if (kind < 5) begin
            start_prog(16'(a), d);
            wait_idle();
            ref_mem[a] = ref_mem[a] & d;
            check_word("R4 random program", a);
         end else if (kind < 7) begin
            start_erase(8'h30, 16'(a));
            wait_idle();
            ref_erase(a, SECT);
            check_word("R5 random sector", a);
         end else begin
            start_erase(8'h50, 16'(a));
            wait_idle();
            ref_erase(a, BLK);
            check_word("R6 random block", a);
         end
         check_word("R3 random read", int'($urandom % WORDS));
      end

      // R6: directed block erase
      start_prog(16'h0045, 16'h0000);
      start_prog(16'h0085, 16'h0000);
      wait_idle();
      wait_idle();
      ref_mem[16'h45] = 16'h0000;
      ref_mem[16'h85] = 16'h0000;
      start_prog(16'h0085, 16'h0000);
      wait_idle();
      start_erase(8'h50, 16'h0070);
      wait_idle();
      ref_erase(16'h70, BLK);
      check_word("R6 block erased", 16'h45);
      check_word("R6 other block kept", 16'h85);

      // R7: chip erase at the wrong address is cancelled
      start_erase(8'h10, 16'h1234);
      brd(16'h0085, r0, e0);
      chk("R7 no busy on wrong address", r0, ref_mem[16'h85]);
      start_erase(8'h10, 16'h5555);
      wait_idle();
      for (int i = 0; i < WORDS; i++) ref_mem[i] = 16'hFFFF;
      for (int i = 0; i < WORDS; i += 17) check_word("R7 chip erased", i);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule